// File: doc/BRIEF.md
# Comma-Aligned 10-Bit Word Deserializer

The block collects a serial bit stream, one bit for each cycle in which the bit enable is high, and cuts it into 10-bit words. Each word is written with its earliest received bit in bit 0. When the sync enable is high, the block watches every 10-bit window of the stream for the comma pattern and moves the word boundary so that the comma becomes a whole word. The block never shortens the gap between words. It drops the strobe that was due and issues the comma word one word period after the comma ends.

Words leave the block on two alternating strobes. Strobe B marks slots 0 and 2 and strobe A marks slots 1 and 3. The comma word is always slot 0 on strobe B, and a one-cycle sync pulse goes with it. A loopback select takes the serial input from the local transmit bit in place of the line input. The whole block runs on one clock and advances only on bit enables.

The controller has three states. In ST_FILL the block is priming after reset. In ST_RUN it cuts words on the free-running boundary. In ST_ALIGN a comma has been seen and the next strobe carries it.
- The transition *primed* goes from ST_FILL to ST_RUN after the first 10 bits.
- The transition *comma seen* goes from any state to ST_ALIGN on a match.
- The transition *comma issued* goes from ST_ALIGN to ST_RUN when the comma word is strobed.

Top module: `comma_deser`

## Requirements
- R1: Each strobed word holds 10 consecutive received bits, with the earliest in bit 0. The word issued at the bit enable numbered c (counted from 1 after reset) holds bits c-19 to c-10.
- R2: While sync enable is low, the first strobe after reset follows bit 20 and every later strobe follows exactly 10 more bits.
- R3: Only the pattern 0011111010 (first-received bit first, which is 10'b0101111100 as bits 9..0) triggers alignment. Its bitwise complement never triggers alignment or sync.
- R4: A comma whose last bit is bit p makes a strobe follow bit p+10, with that comma as the word. Any strobe that was due in between is dropped, and strobes then follow every 10 bits. No two strobes are ever fewer than 10 bit enables apart.
- R5: Strobes A and B are never high together. Counting slots 0 to 3, B is used for even slots and A for odd slots. The comma word is slot 0, so B may occur twice in a row.
- R6: The sync pulse is high for exactly the one cycle of the comma word's strobe B, and only while sync enable is high.
- R7: While loopback is high, the transmit bit is the serial input and the line input has no effect.
- R8: During reset all outputs are 0. After reset no strobe occurs before bit 20, and the first strobe is B.
- R9: Strobes and sync are one-cycle pulses in the cycle after a bit enable. The word output holds its value between strobes.
- R10: A comma that ends on the current boundary causes no realignment. The strobe due at that bit still occurs, and the comma word follows 10 bits later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One serial bit is taken in this cycle |
| rx_bit | input | 1 | Serial bit from the line |
| tx_bit | input | 1 | Local transmit bit, used in loopback |
| loop_en | input | 1 | Selects tx_bit as the serial input |
| sync_en | input | 1 | Enables comma search and realignment |
| word_out | output | 10 | Assembled word, bit 0 received first |
| strobe_a | output | 1 | Word strobe for slots 1 and 3 |
| strobe_b | output | 1 | Word strobe for slots 0 and 2 |
| sync_pulse | output | 1 | Marks the comma word |

## Verification
The assertions take for granted three things about the inputs. The bit enable is a one-cycle pulse. The sync enable stays steady from the moment a comma is seen until the comma word has been issued. Commas do not overlap one another. The stimulus keeps within these limits by spacing each bit enable with an idle cycle and by fixing sync enable and loopback for each whole vector. It pads the comma with alternating filler and data words that have no run of five ones, so the only match in the stream is the one that was planted.

// File: rtl/comma_deser_pkg.sv
package comma_deser_pkg;

    // Comma pattern written as bits 9..0, so bit 0 is the first bit received.
    localparam logic [9:0] COMMA_NEG = 10'b0101111100;

    typedef enum logic [1:0] {
        ST_FILL,
        ST_RUN,
        ST_ALIGN
    } ctrl_state_e;

endpackage

// File: rtl/deser_shift.sv
module deser_shift #(
    parameter int WORD_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bit_en,
    input  logic                  rx_bit,
    input  logic                  tx_bit,
    input  logic                  loop_en,
    output logic [2*WORD_W-1:0]   win_next
);
    localparam int SW = 2 * WORD_W;

    logic [SW-1:0] win_q;
    logic          ser_in;

    // Loopback picks the local transmit bit and ignores the line input.
    assign ser_in   = loop_en ? tx_bit : rx_bit;
    // The newest bit enters at the top. The lower half is the word one period old.
    assign win_next = {ser_in, win_q[SW-1:1]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (bit_en) begin
            win_q <= win_next;
        end
    end
endmodule

// File: rtl/comma_match.sv
module comma_match #(
    parameter int                WORD_W  = 10,
    parameter logic [WORD_W-1:0] PATTERN = comma_deser_pkg::COMMA_NEG
) (
    input  logic [WORD_W-1:0] window,
    input  logic              enable,
    output logic              hit
);
    // Exact match only: the complementary form is a different value and never hits.
    assign hit = enable && (window == PATTERN);
endmodule

// File: rtl/deser_ctrl.sv
module deser_ctrl
    import comma_deser_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              sync_en,
    input  logic              comma_hit,
    input  logic [WORD_W-1:0] old_word,
    output logic [WORD_W-1:0] word_out,
    output logic              strobe_a,
    output logic              strobe_b,
    output logic              sync_pulse
);
    localparam int          CW   = $clog2(WORD_W);
    localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

    ctrl_state_e   state, state_n;
    logic [CW-1:0] cnt, cnt_n;
    logic [1:0]    slot;
    logic          fire;

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        fire    = 1'b0;
        if (bit_en) begin
            cnt_n = (cnt == LAST) ? '0 : cnt + 1'b1;
            unique case (state)
                ST_FILL:  if (cnt == LAST) state_n = ST_RUN;      // primed
                ST_RUN:   fire = (cnt == LAST);
                ST_ALIGN: if (cnt == LAST) begin                  // comma issued
                              fire    = 1'b1;
                              state_n = ST_RUN;
                          end
                default:  state_n = ST_FILL;
            endcase
            if (comma_hit) begin                                  // comma seen
                state_n = ST_ALIGN;
                cnt_n   = '0;
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_FILL;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out   <= '0;
            strobe_a   <= 1'b0;
            strobe_b   <= 1'b0;
            sync_pulse <= 1'b0;
            slot       <= 2'd0;
        end else begin
            strobe_a   <= 1'b0;
            strobe_b   <= 1'b0;
            sync_pulse <= 1'b0;
            if (fire) begin
                word_out <= old_word;
                if (state == ST_ALIGN) begin
                    strobe_b   <= 1'b1;
                    sync_pulse <= sync_en;
                    slot       <= 2'd1;
                end else begin
                    strobe_b <= ~slot[0];
                    strobe_a <= slot[0];
                    slot     <= slot + 2'd1;
                end
            end
        end
    end
endmodule

// File: rtl/comma_deser.sv
module comma_deser #(
    parameter int                WORD_W    = 10,
    parameter logic [WORD_W-1:0] COMMA_PAT = comma_deser_pkg::COMMA_NEG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              rx_bit,
    input  logic              tx_bit,
    input  logic              loop_en,
    input  logic              sync_en,
    output logic [WORD_W-1:0] word_out,
    output logic              strobe_a,
    output logic              strobe_b,
    output logic              sync_pulse
);
    logic [2*WORD_W-1:0] win_next;
    logic                comma_hit;

    deser_shift #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .rx_bit   (rx_bit),
        .tx_bit   (tx_bit),
        .loop_en  (loop_en),
        .win_next (win_next)
    );

    comma_match #(.WORD_W(WORD_W), .PATTERN(COMMA_PAT)) u_match (
        .window (win_next[2*WORD_W-1:WORD_W]),
        .enable (bit_en && sync_en),
        .hit    (comma_hit)
    );

    deser_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .sync_en    (sync_en),
        .comma_hit  (comma_hit),
        .old_word   (win_next[WORD_W-1:0]),
        .word_out   (word_out),
        .strobe_a   (strobe_a),
        .strobe_b   (strobe_b),
        .sync_pulse (sync_pulse)
    );
endmodule

// File: rtl/comma_deser_chk.sv
module comma_deser_chk #(
    parameter int                WORD_W    = 10,
    parameter logic [WORD_W-1:0] COMMA_PAT = comma_deser_pkg::COMMA_NEG
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_en,
    input logic              sync_en,
    input logic [WORD_W-1:0] word_out,
    input logic              strobe_a,
    input logic              strobe_b,
    input logic              sync_pulse
);
    localparam int GW = $clog2(2 * WORD_W + 1) + 1;

    logic [GW-1:0] gap;
    logic          any_strobe;

    assign any_strobe = strobe_a || strobe_b;

    // Bit enables counted since the last visible strobe, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap <= '0;
        end else if (any_strobe) begin
            gap <= bit_en ? GW'(1) : '0;
        end else if (bit_en && gap < GW'(2 * WORD_W)) begin
            gap <= gap + 1'b1;
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe_a && strobe_b)); // R5

    AST_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        any_strobe |-> gap >= GW'(WORD_W)); // R4

    AST_SYNC_IS_COMMA: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |-> (strobe_b && word_out == COMMA_PAT)); // R6

    AST_SYNC_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |-> $past(sync_en)); // R6

    AST_STROBE_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        any_strobe |-> $past(bit_en)); // R9

    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !any_strobe |-> $stable(word_out)); // R9
endmodule

bind comma_deser comma_deser_chk #(.WORD_W(WORD_W), .COMMA_PAT(COMMA_PAT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .sync_en    (sync_en),
    .word_out   (word_out),
    .strobe_a   (strobe_a),
    .strobe_b   (strobe_b),
    .sync_pulse (sync_pulse)
);

// File: tb/tb_comma_deser.sv
`timescale 1ns/1ps
module tb_comma_deser;
    localparam logic [9:0] COMMA = 10'b0101111100;
    localparam int NVEC = 9;
    // Fields: {offset[4:0], negative form, sync_en, loop_en}
    localparam logic [7:0] VEC [0:NVEC-1] = '{
        {5'd0,  1'b1, 1'b1, 1'b0},
        {5'd3,  1'b1, 1'b1, 1'b0},
        {5'd7,  1'b1, 1'b1, 1'b1},
        {5'd10, 1'b1, 1'b1, 1'b0},
        {5'd15, 1'b1, 1'b1, 1'b0},
        {5'd4,  1'b0, 1'b1, 1'b0},
        {5'd6,  1'b1, 1'b0, 1'b0},
        {5'd12, 1'b0, 1'b1, 1'b1},
        {5'd20, 1'b1, 1'b1, 1'b1}
    };
    localparam logic [9:0] DATA [0:3] = '{10'h155, 10'h0F3, 10'h2AA, 10'h155};

    logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0;
    logic rx_bit = 1'b0, tx_bit = 1'b0, loop_en = 1'b0, sync_en = 1'b0;
    logic [9:0] word_out;
    logic strobe_a, strobe_b, sync_pulse;

    always #2 clk = ~clk;

    comma_deser dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
        .tx_bit(tx_bit), .loop_en(loop_en), .sync_en(sync_en),
        .word_out(word_out), .strobe_a(strobe_a), .strobe_b(strobe_b),
        .sync_pulse(sync_pulse)
    );

    int checks = 0, fails = 0;
    logic s [0:255];
    int nb, last_strobe, slot, p;
    bit align, seen_align, neg;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n  = 1'b0;
        bit_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(word_out == 0 && !strobe_a && !strobe_b && !sync_pulse, "R8",
            "outputs in reset", {word_out, strobe_a, strobe_b, sync_pulse}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        nb = 0; last_strobe = 0; slot = 0; seen_align = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        logic [9:0] prev, exp_word;
        bit exp_s, is_al;
        string tag;
        if (loop_en) begin tx_bit = b; rx_bit = ~b; end
        else begin rx_bit = b; tx_bit = ~b; end
        bit_en = 1'b1;
        @(negedge clk);
        nb++;
        bit_en = 1'b0;
        exp_s = (nb >= 20 && nb % 10 == 0 && (!align || nb <= p))
             || (align && nb >= p + 10 && (nb - p) % 10 == 0);
        tag = !align ? "R2" : (nb == p && p >= 20 && p % 10 == 0) ? "R10" : "R4";
        if (nb < 20) tag = "R8";
        chk((strobe_a | strobe_b) == exp_s, tag, $sformatf("strobe at bit %0d", nb),
            int'(strobe_a | strobe_b), int'(exp_s));
        if (strobe_a | strobe_b) begin
            chk(!(strobe_a && strobe_b), "R5", "both strobes", 1, 0);
            chk(nb - last_strobe >= 10, "R4", "strobe spacing", nb - last_strobe, 10);
            for (int k = 0; k < 10; k++) exp_word[k] = s[nb - 19 + k];
            chk(word_out == exp_word, loop_en ? "R7" : "R1", "word", int'(word_out), int'(exp_word));
            is_al = align && (nb == p + 10);
            if (is_al) slot = 0;
            chk(strobe_b == (slot % 2 == 0), "R5", $sformatf("strobe_b slot %0d", slot),
                int'(strobe_b), int'(slot % 2 == 0));
            slot = (slot + 1) % 4;
            chk(sync_pulse == is_al, neg ? "R6" : "R3", "sync", int'(sync_pulse), int'(is_al));
            if (is_al) seen_align = 1'b1;
            last_strobe = nb;
        end else begin
            chk(!sync_pulse, "R6", "sync without strobe", int'(sync_pulse), 0);
        end
        prev = word_out;
        @(negedge clk);
        chk(!strobe_a && !strobe_b && !sync_pulse && word_out == prev, "R9",
            "idle cycle", {strobe_a, strobe_b, sync_pulse}, 0);
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int v = 0; v < NVEC; v++) begin
            int off, n;
            off     = int'(VEC[v][7:3]);
            neg     = VEC[v][2];
            sync_en = VEC[v][1];
            loop_en = VEC[v][0];
            p       = off + 10;
            align   = neg && sync_en;
            n       = p + 45;
            for (int i = 1; i <= n; i++) s[i] = i[0];
            for (int k = 0; k < 10; k++) s[off + 1 + k] = neg ? COMMA[k] : ~COMMA[k];
            for (int w = 0; w < 4; w++)
                for (int k = 0; k < 10; k++) s[p + 1 + w * 10 + k] = DATA[w][k];
            do_reset();
            for (int i = 1; i <= n; i++) send_bit(s[i]);
            if (align) chk(seen_align, "R4", "comma word issued", int'(seen_align), 1);
        end
        // Directed: reset in the middle of a stream clears the outputs (R8)
        sync_en = 1'b0; loop_en = 1'b0; align = 1'b0; neg = 1'b1;
        for (int i = 1; i <= 40; i++) s[i] = i[1];
        do_reset();
        for (int i = 1; i <= 25; i++) send_bit(s[i]);
        do_reset();
        for (int i = 1; i <= 30; i++) send_bit(s[i]);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule